// File: doc/BRIEF.md
# Three-Channel Timer Counters with Synchronous Grouping

The block holds three up-counters on one small register bus. Each counter runs on every clock while its start bit is set and holds while it is clear. Each channel has a compare register, a clear-select field and an output-control register that drives one compare pin. A channel can clear itself on a compare match. On a match its pin can go low, go high, toggle or keep its level. A channel that is halted keeps its pin level. Rewriting its output-control register while it is halted forces the pin to the programmed initial level.

A sync register can bind channels into one group. The group is active only when two or more channels are flagged. A software write to the counter of any group member then loads every member. A member whose clear select asks for group clearing returns to zero whenever another member clears on its own match. Software uses this to keep several counters phase-locked with one write and one compare.

Top module: `tmr_sync3`

## Requirements
- R1: After reset all start bits and sync bits are 0, every counter and every pin is 0, clear selects and output controls are 0, and every compare register holds all ones.
- R2: The start register is at address 0, with bit k belonging to channel k. A running counter advances by one on every clock. A halted counter keeps its value and is changed only by a software preset.
- R3: The sync register is at address 1. Bits 2..0 store the sync flags of channels 2..0. Bits above 2 always read 0 and ignore writes.
- R4: Channel k's registers are at address 4(k+1)+o. Offset o is 0 for the counter, 1 for compare, 2 for clear select and 3 for output control. A write to a counter loads that counter. When the group is active and the written channel is flagged, every flagged channel loads the same value in the same cycle.
- R5: With fewer than two sync flags set, a counter write loads only the addressed counter.
- R6: Clear select 1 makes a running counter go to 0 on the clock after it equals its compare value. Run from 0, the counter therefore repeats with a period of compare+1. Clear select 0 (and 3..7) never clears.
- R7: Clear select 2 makes a running counter in an active group go to 0 in the same clock in which a flagged member with clear select 1 clears on its match. Nothing happens when the channel is unflagged, when the group is inactive, or when the channel has clear select 0.
- R8: A counter preset wins over a compare clear and over an increment in the same clock.
- R9: Output control bit 0 is the initial level, and bits 2:1 set the match action: 0 hold, 1 drive low, 2 drive high, 3 toggle. The action is applied on the clock of each match of a running channel.
- R10: A halted channel's pin keeps its level. A write to output control while halted drives the pin to the new bit 0 on that clock. The same write while running only stores the register and leaves the pin as it is.
- R11: A read returns, on the clock after the address is presented, the register value from before that clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 4 | Register address |
| bus_we | input | 1 | Write strobe for bus_addr |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| cmp_pin | output | 3 | Compare output pin per channel |

## Verification
The hardest case is a group clear. It needs two flagged counters that start from the same preset in the same clock, one of them with own-match clearing and the other with group clearing. The bench reaches it by loading the whole group with a single counter write while both channels are halted. It then starts both through one start-register write and stops them after a swept number of clocks. The follower's count must then match the leader's count modulo (compare+1). The same sweep is repeated with the follower unflagged, with the group reduced to one flag, and with the follower's clear select at 0, and in each of these the follower must show the plain count.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [2:0] {
    CLR_NONE  = 3'd0,
    CLR_OWN   = 3'd1,
    CLR_GROUP = 3'd2
  } clr_sel_e;

  typedef enum logic [1:0] {
    ACT_HOLD   = 2'd0,
    ACT_LOW    = 2'd1,
    ACT_HIGH   = 2'd2,
    ACT_TOGGLE = 2'd3
  } pin_act_e;

  localparam int unsigned REG_START = 0;
  localparam int unsigned REG_SYNC  = 1;
  localparam int unsigned CH_STRIDE = 4;
  localparam int unsigned OFS_CNT   = 0;
  localparam int unsigned OFS_CMP   = 1;
  localparam int unsigned OFS_CLR   = 2;
  localparam int unsigned OFS_OUT   = 3;

  function automatic int unsigned ch_addr(int unsigned ch, int unsigned ofs);
    return CH_STRIDE * (ch + 1) + ofs;
  endfunction
endpackage

// File: rtl/tmr_sync_ctl.sv
module tmr_sync_ctl #(
  parameter int NCH = 3
) (
  input  logic [NCH-1:0] sync_bits,
  input  logic [NCH-1:0] match,
  input  logic [NCH-1:0] clr_own,
  output logic [NCH-1:0] member,
  output logic           grp_clr
);
  localparam int CNTW = $clog2(NCH + 1);

  logic [CNTW-1:0] n_set;

  always_comb begin
    n_set = '0;
    for (int i = 0; i < NCH; i++) n_set = n_set + CNTW'(sync_bits[i]);
  end

  assign member  = (n_set >= CNTW'(2)) ? sync_bits : '0;
  assign grp_clr = |(member & match & clr_own);
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
  import tmr_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          preset_en,
  input  logic [CW-1:0] wdata,
  input  logic          cmp_we,
  input  logic          clr_we,
  input  logic          out_we,
  input  logic          member,
  input  logic          grp_clr,
  output logic [CW-1:0] cnt,
  output logic [CW-1:0] cmp,
  output logic [2:0]    clr_sel,
  output logic [2:0]    outctl,
  output logic          pin,
  output logic          match,
  output logic          clr_own
);
  logic [CW-1:0] cnt_d;
  logic          cnt_en;
  logic          pin_d;
  logic          do_clr;
  pin_act_e      act;

  assign match   = run && (cnt == cmp);
  assign clr_own = (clr_sel == CLR_OWN);
  assign act     = pin_act_e'(outctl[2:1]);
  assign do_clr  = (match && clr_own) ||
                   (member && (clr_sel == CLR_GROUP) && grp_clr);
  assign cnt_en  = preset_en || run;

  always_comb begin
    if (preset_en)   cnt_d = wdata;
    else if (do_clr) cnt_d = '0;
    else             cnt_d = cnt + CW'(1);
  end

  always_comb begin
    pin_d = pin;
    if (out_we && !run) pin_d = wdata[0];
    else if (match) begin
      unique case (act)
        ACT_LOW:    pin_d = 1'b0;
        ACT_HIGH:   pin_d = 1'b1;
        ACT_TOGGLE: pin_d = ~pin;
        default:    pin_d = pin;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      cmp     <= '1;
      clr_sel <= '0;
      outctl  <= '0;
      pin     <= 1'b0;
    end else begin
      if (cnt_en) cnt     <= cnt_d;
      if (cmp_we) cmp     <= wdata;
      if (clr_we) clr_sel <= wdata[2:0];
      if (out_we) outctl  <= wdata[2:0];
      pin <= pin_d;
    end
  end
endmodule

// File: rtl/tmr_sync3.sv
module tmr_sync3
  import tmr_pkg::*;
#(
  parameter  int NCH = 3,
  parameter  int CW  = 16,
  localparam int AW  = $clog2(CH_STRIDE * (NCH + 1))
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_we,
  input  logic [CW-1:0] bus_wdata,
  output logic [CW-1:0] bus_rdata,
  output logic [NCH-1:0] cmp_pin
);
  logic [1:0]               rst_pipe;
  logic                     rst_q_n;
  logic [NCH-1:0]           start_q;
  logic [NCH-1:0]           sync_q;
  logic [NCH-1:0]           wr_cnt, wr_cmp, wr_clr, wr_out;
  logic [NCH-1:0]           member, match, clr_own, preset_en;
  logic                     grp_clr, any_member_wr;
  logic [NCH-1:0][CW-1:0]   cnt_all, cmp_all;
  logic [NCH-1:0][2:0]      clr_all, out_all;
  logic [CW-1:0]            rd_d;
  logic                     wr_start, wr_sync;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_q_n = rst_pipe[1];

  assign wr_start = bus_we && (bus_addr == AW'(REG_START));
  assign wr_sync  = bus_we && (bus_addr == AW'(REG_SYNC));

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      start_q <= '0;
      sync_q  <= '0;
    end else begin
      if (wr_start) start_q <= bus_wdata[NCH-1:0];
      if (wr_sync)  sync_q  <= bus_wdata[NCH-1:0];
    end
  end

  tmr_sync_ctl #(.NCH(NCH)) u_sync (
    .sync_bits (sync_q),
    .match     (match),
    .clr_own   (clr_own),
    .member    (member),
    .grp_clr   (grp_clr)
  );

  assign any_member_wr = |(wr_cnt & member);
  assign preset_en     = wr_cnt | (member & {NCH{any_member_wr}});

  for (genvar k = 0; k < NCH; k++) begin : g_ch
    assign wr_cnt[k] = bus_we && (bus_addr == AW'(ch_addr(k, OFS_CNT)));
    assign wr_cmp[k] = bus_we && (bus_addr == AW'(ch_addr(k, OFS_CMP)));
    assign wr_clr[k] = bus_we && (bus_addr == AW'(ch_addr(k, OFS_CLR)));
    assign wr_out[k] = bus_we && (bus_addr == AW'(ch_addr(k, OFS_OUT)));

    tmr_chan #(.CW(CW)) u_chan (
      .clk       (clk),
      .rst_n     (rst_q_n),
      .run       (start_q[k]),
      .preset_en (preset_en[k]),
      .wdata     (bus_wdata),
      .cmp_we    (wr_cmp[k]),
      .clr_we    (wr_clr[k]),
      .out_we    (wr_out[k]),
      .member    (member[k]),
      .grp_clr   (grp_clr),
      .cnt       (cnt_all[k]),
      .cmp       (cmp_all[k]),
      .clr_sel   (clr_all[k]),
      .outctl    (out_all[k]),
      .pin       (cmp_pin[k]),
      .match     (match[k]),
      .clr_own   (clr_own[k])
    );
  end

  always_comb begin
    rd_d = '0;
    if (bus_addr == AW'(REG_START)) rd_d = CW'(start_q);
    if (bus_addr == AW'(REG_SYNC))  rd_d = CW'(sync_q);
    for (int i = 0; i < NCH; i++) begin
      if (bus_addr == AW'(ch_addr(i, OFS_CNT))) rd_d = cnt_all[i];
      if (bus_addr == AW'(ch_addr(i, OFS_CMP))) rd_d = cmp_all[i];
      if (bus_addr == AW'(ch_addr(i, OFS_CLR))) rd_d = CW'(clr_all[i]);
      if (bus_addr == AW'(ch_addr(i, OFS_OUT))) rd_d = CW'(out_all[i]);
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) bus_rdata <= '0;
    else          bus_rdata <= rd_d;
  end
endmodule

// File: rtl/tmr_sync3_chk.sv
module tmr_sync3_chk #(
  parameter int NCH = 3,
  parameter int CW  = 16,
  parameter int AW  = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [NCH-1:0]         run,
  input logic [NCH-1:0][CW-1:0] cnt,
  input logic [NCH-1:0]         pin,
  input logic                   we,
  input logic [AW-1:0]          addr,
  input logic [CW-1:0]          wdata,
  input logic [CW-1:0]          rdata
);
  // R3: reserved sync bits read as zero
  a_r3_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == AW'(1)) |=> (rdata[CW-1:NCH] == '0));

  for (genvar k = 0; k < NCH; k++) begin : g_k
    // R2: halted counter frozen without a bus write
    a_r2_halt_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (!run[k] && !we) |=> $stable(cnt[k]));
    // R2 / R6 / R7: running counter steps by one or clears
    a_r2_step_or_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (run[k] && !we) |=> ((cnt[k] == $past(cnt[k]) + CW'(1)) || (cnt[k] == '0)));
    // R4 / R8: direct counter write always lands
    a_r4_preset_lands: assert property (@(posedge clk) disable iff (!rst_n)
      (we && addr == AW'(4 * (k + 1))) |=> (cnt[k] == $past(wdata)));
    // R10: halted pin keeps level unless its output control is written
    a_r10_pin_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!run[k] && !(we && addr == AW'(4 * (k + 1) + 3))) |=> $stable(pin[k]));
  end
endmodule

bind tmr_sync3 tmr_sync3_chk #(.NCH(NCH), .CW(CW), .AW(AW)) u_chk (
  .clk   (clk),
  .rst_n (rst_q_n),
  .run   (start_q),
  .cnt   (cnt_all),
  .pin   (cmp_pin),
  .we    (bus_we),
  .addr  (bus_addr),
  .wdata (bus_wdata),
  .rdata (bus_rdata)
);

// File: tb/sim_tmr_sync3.sv
module sim_tmr_sync3;
  localparam int CW = 16, NCH = 3, AW = 4;

  logic           clk = 1'b0;
  logic           rst_n;
  logic [AW-1:0]  addr;
  logic           we;
  logic [CW-1:0]  wdata;
  logic [CW-1:0]  rdata;
  logic [NCH-1:0] pin;
  int             total = 0;
  int             fails = 0;
  int             cyc = 0;
  logic [CW-1:0]  v, v2;

  always #10 clk = ~clk;

  tmr_sync3 #(.NCH(NCH), .CW(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we),
    .bus_wdata(wdata), .bus_rdata(rdata), .cmp_pin(pin)
  );

  function automatic int ca(int ch, int ofs);
    return 4 * (ch + 1) + ofs;
  endfunction

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(int a, int d);
    addr = AW'(a); wdata = CW'(d); we = 1'b1;
    @(posedge clk); @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(int a, output logic [CW-1:0] val);
    addr = AW'(a); we = 1'b0;
    @(posedge clk); @(negedge clk);
    val = rdata;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  // run channels in mask for exactly n increments (n >= 1)
  task automatic run_n(int mask, int n);
    wr(0, mask);
    idle(n - 1);
    wr(0, 0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        total++; fails++;
        $display("FAIL watchdog actual=%0d expected=done", cyc);
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
      end
    end
  end

  initial begin
    rst_n = 1'b0; we = 1'b0; addr = '0; wdata = '0;
    idle(3);
    rst_n = 1'b1;
    idle(4);

    // R1 reset state
    chk("R1 pins", int'(pin), 0);
    rd(0, v); chk("R1 start", int'(v), 0);
    rd(1, v); chk("R1 sync", int'(v), 0);
    for (int k = 0; k < NCH; k++) begin
      rd(ca(k, 0), v); chk("R1 cnt", int'(v), 0);
      rd(ca(k, 1), v); chk("R1 cmp", int'(v), 16'hFFFF);
      rd(ca(k, 2), v); chk("R1 clr", int'(v), 0);
      rd(ca(k, 3), v); chk("R1 out", int'(v), 0);
    end

    // R3 reserved sync bits; R11 read returns written data
    wr(1, 16'h00FF); rd(1, v); chk("R3 sync mask", int'(v), 7);
    wr(1, 16'h00A5); rd(1, v); chk("R3 sync mask", int'(v), 5);
    wr(1, 0);
    wr(ca(1, 1), 16'h1234); rd(ca(1, 1), v); chk("R11 cmp readback", int'(v), 16'h1234);
    wr(ca(1, 1), 16'hFFFF);

    // R2 count and hold sweep on channel 2
    for (int n = 1; n <= 6; n++) begin
      wr(ca(2, 0), 0);
      run_n(4, n);
      rd(ca(2, 0), v); chk("R2 count", int'(v), n);
      idle(n);
      rd(ca(2, 0), v); chk("R2 halted hold", int'(v), n);
    end

    // R6 own-match clear and R9 toggle, swept
    wr(ca(0, 2), 1);
    for (int c = 0; c <= 3; c++) begin
      for (int n = 1; n <= 9; n++) begin
        wr(ca(0, 1), c);
        wr(ca(0, 3), 6);
        chk("R10 init on halted write", int'(pin[0]), 0);
        wr(ca(0, 0), 0);
        run_n(1, n);
        rd(ca(0, 0), v); chk("R6 clear period", int'(v), n % (c + 1));
        chk("R9 toggle pin", int'(pin[0]), (n / (c + 1)) % 2);
      end
    end

    // R9 other actions, compare 2, five increments
    wr(ca(0, 1), 2);
    wr(ca(0, 3), 4); wr(ca(0, 0), 0); run_n(1, 5);
    chk("R9 drive high", int'(pin[0]), 1);
    wr(ca(0, 3), 3); wr(ca(0, 0), 0); run_n(1, 5);
    chk("R9 drive low", int'(pin[0]), 0);
    wr(ca(0, 3), 1); wr(ca(0, 0), 0); run_n(1, 5);
    chk("R9 hold action", int'(pin[0]), 1);

    // R10 halted hold, halted write, running write
    wr(ca(0, 3), 7);
    chk("R10 halted write high", int'(pin[0]), 1);
    idle(5);
    chk("R10 halted pin hold", int'(pin[0]), 1);
    wr(ca(0, 1), 16'hFFFF); wr(ca(0, 0), 0);
    wr(0, 1);
    wr(ca(0, 3), 6);
    chk("R10 running write no pin change", int'(pin[0]), 1);
    idle(2); wr(0, 0);
    chk("R10 pin after stop", int'(pin[0]), 1);
    rd(ca(0, 3), v); chk("R10 stored while running", int'(v), 6);
    wr(ca(0, 3), 6);
    chk("R10 halted write low", int'(pin[0]), 0);

    // R4 group preset, R5 single-flag independence
    wr(ca(2, 0), 16'h0055);
    wr(1, 3);
    wr(ca(0, 0), 16'h0ABC);
    rd(ca(0, 0), v); chk("R4 member ch0", int'(v), 16'h0ABC);
    rd(ca(1, 0), v); chk("R4 member ch1", int'(v), 16'h0ABC);
    rd(ca(2, 0), v); chk("R4 non-member ch2", int'(v), 16'h0055);
    wr(ca(2, 0), 16'h0077);
    rd(ca(0, 0), v); chk("R4 non-member write", int'(v), 16'h0ABC);
    wr(1, 1);
    wr(ca(0, 0), 16'h0222);
    rd(ca(1, 0), v); chk("R5 single flag ch1", int'(v), 16'h0ABC);
    wr(1, 4);
    wr(ca(2, 0), 16'h0333);
    rd(ca(0, 0), v); chk("R5 single flag ch0", int'(v), 16'h0222);
    rd(ca(2, 0), v); chk("R5 single flag ch2", int'(v), 16'h0333);

    // R7 group clear sweep
    wr(ca(0, 2), 1); wr(ca(0, 1), 3); wr(ca(1, 1), 16'hFFFF);
    for (int n = 1; n <= 8; n++) begin
      wr(1, 3); wr(ca(1, 2), 2);
      wr(ca(0, 0), 0);
      run_n(3, n);
      rd(ca(0, 0), v);  chk("R7 leader", int'(v), n % 4);
      rd(ca(1, 0), v2); chk("R7 follower", int'(v2), n % 4);
      wr(ca(1, 2), 0); wr(ca(0, 0), 0);
      run_n(3, n);
      rd(ca(1, 0), v); chk("R7 clear select 0", int'(v), n);
      wr(ca(1, 2), 2); wr(1, 2);
      wr(ca(0, 0), 0); wr(ca(1, 0), 0);
      run_n(3, n);
      rd(ca(1, 0), v); chk("R7 group inactive", int'(v), n);
      wr(1, 1);
      wr(ca(0, 0), 0); wr(ca(1, 0), 0);
      run_n(3, n);
      rd(ca(1, 0), v); chk("R7 follower unflagged", int'(v), n);
    end
    wr(1, 0);

    // R8 priorities on channel 2
    wr(ca(2, 2), 0); wr(ca(2, 1), 16'hFFFF); wr(ca(2, 0), 0);
    wr(0, 4); idle(3); wr(ca(2, 0), 100); wr(0, 0);
    rd(ca(2, 0), v); chk("R8 preset over increment", int'(v), 101);
    wr(ca(2, 2), 1); wr(ca(2, 1), 7); wr(ca(2, 0), 0);
    wr(0, 4); wr(ca(2, 0), 7); wr(ca(2, 0), 20); wr(0, 0);
    rd(ca(2, 0), v); chk("R8 preset over clear", int'(v), 21);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule